// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each side has a capture register, and each transfer direction has its own output enable and its own data select. The A-to-B direction drives the B pins. It sends either the live value seen on bus A or the value held in the A-side register. The B-to-A direction drives the A pins in the same way, using live bus B data or the B-side register. The enable for the A-to-B direction is active high. The enable for the B-to-A direction is active low.

Pins are modelled as separate input, output and output-enable vectors, so the block needs no tristate logic. The two register clocks are treated as strobes. They are synchronised to the system clock, and a register loads on each rising edge of its strobe. A register always captures what is on its own bus. When that side is being driven by the block, this is the value the block drives.

When both sides drive in live mode, each output would depend on the other. The block breaks this loop with a per-side keeper register. The keeper holds the last settled bus value, so each bus keeps its state.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high `rst` clears both capture registers to 0x00, so stored-mode outputs read 0x00 after reset.
- R2: `b_oe` is 1 exactly when `en_ab` is 1, and `a_oe` is 1 exactly when `en_ba_n` is 0.
- R3: With `en_ab`=0 and `en_ba_n`=1, neither side drives (isolation), and both registers can still be loaded.
- R4: The A-side register loads the bus A value on the third rising `clk` edge after `cap_ab` is seen rising, whatever the enables and selects are.
- R5: The B-side register loads the bus B value on the third rising `clk` edge after `cap_ba` is seen rising, whatever the enables and selects are.
- R6: With a select at 0 and the opposite side not driving, the enabled output equals the live input of the opposite bus (`sel_ab`=0: `b_out`=`a_in`; `sel_ba`=0: `a_out`=`b_in`).
- R7: With a select at 1, the enabled output is the stored register (`sel_ab`=1: `b_out` = A-side register; `sel_ba`=1: `a_out` = B-side register).
- R8: With both sides driving and both selects at 1, `b_out` carries the stored A value and `a_out` carries the stored B value at the same time.
- R9: With both sides driving and both selects at 0, each output holds the last value its own bus had before this mode was entered, for as long as the mode lasts.
- R10: A register loads the value its side is driving. With B driving live A data, a `cap_ba` edge stores the bus A value into the B-side register.
- R11: A select change reaches the output in the same cycle with no clock latency. When stored and live values are equal, toggling the select leaves the output unchanged.
- R12: A strobe held high causes one capture only. Later bus changes are not loaded until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_ab | input | 1 | A-to-B enable, active high, drives the B pins |
| en_ba_n | input | 1 | B-to-A enable, active low, drives the A pins |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| cap_ab | input | 1 | Capture strobe for the A-side register |
| cap_ba | input | 1 | Capture strobe for the B-side register |
| a_in | input | 8 | Value observed on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | 8 | Value observed on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
The bench sweeps a set of byte patterns, where each pattern is paired with its complement on the other bus. It tries every enable and select combination on them. This separates the live paths from the stored paths and shows that the two directions never swap data. Captures are made while the block is isolated and while it drives, which shows that a register takes the driven value when its side is active. Separate sequences cover the held-strobe case, the both-live keeper case, and select toggling with equal and with differing data.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    typedef enum logic [1:0] {
        ROUTE_OFF    = 2'd0,
        ROUTE_LIVE   = 2'd1,
        ROUTE_STORED = 2'd2,
        ROUTE_KEEP   = 2'd3
    } route_e;

    // Pick the source for one driving side.
    function automatic route_e pick_route(input logic drives_here,
                                          input logic sel_here,
                                          input logic drives_other,
                                          input logic sel_other);
        if (!drives_here)                     return ROUTE_OFF;
        else if (sel_here)                    return ROUTE_STORED;
        else if (drives_other && !sel_other)  return ROUTE_KEEP;
        else                                  return ROUTE_LIVE;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] sync;
        logic         prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], strobe_i};
        st_d.prev = st_q.sync[TOP];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o = st_q.sync[TOP] & ~st_q.prev;

    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.data = d_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_o = st_q.data;

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (q_o == $past(d_i)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/route_sel.sv
module route_sel
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  route_e           route_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] y_o
);
    // Output depends only on the current route and data; no decode hazard state.
    always_comb begin
        unique case (route_i)
            ROUTE_LIVE:   y_o = live_i;
            ROUTE_STORED: y_o = stored_i;
            ROUTE_KEEP:   y_o = keep_i;
            default:      y_o = keep_i;
        endcase
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import bxr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam int NSIDE = 2;

    logic             drive_a, drive_b;
    logic [NSIDE-1:0] strobe_vec, rise_vec;
    route_e           route_a, route_b;
    logic [WIDTH-1:0] reg_a_q, reg_b_q, keep_a_q, keep_b_q;
    logic [WIDTH-1:0] live_to_a, live_to_b, a_seen, b_seen;
    logic [WIDTH-1:0] a_drive, b_drive;

    assign drive_a = ~en_ba_n;
    assign drive_b = en_ab;

    assign strobe_vec = {cap_ba, cap_ab};

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_strobe
            strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk(clk), .rst(rst),
                .strobe_i(strobe_vec[s]), .rise_o(rise_vec[s])
            );
        end
    endgenerate

    always_comb begin
        route_a   = pick_route(drive_a, sel_ba, drive_b, sel_ab);
        route_b   = pick_route(drive_b, sel_ab, drive_a, sel_ba);
        live_to_a = drive_b ? reg_a_q : b_in;
        live_to_b = drive_a ? reg_b_q : a_in;
    end

    route_sel #(.WIDTH(WIDTH)) u_sel_a (
        .route_i(route_a), .live_i(live_to_a), .stored_i(reg_b_q),
        .keep_i(keep_a_q), .y_o(a_drive)
    );

    route_sel #(.WIDTH(WIDTH)) u_sel_b (
        .route_i(route_b), .live_i(live_to_b), .stored_i(reg_a_q),
        .keep_i(keep_b_q), .y_o(b_drive)
    );

    assign a_seen = drive_a ? a_drive : a_in;
    assign b_seen = drive_b ? b_drive : b_in;

    capture_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(clk), .rst(rst), .load_i(rise_vec[0]), .d_i(a_seen), .q_o(reg_a_q)
    );
    capture_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(clk), .rst(rst), .load_i(rise_vec[1]), .d_i(b_seen), .q_o(reg_b_q)
    );
    capture_reg #(.WIDTH(WIDTH)) u_keep_a (
        .clk(clk), .rst(rst), .load_i(1'b1), .d_i(a_seen), .q_o(keep_a_q)
    );
    capture_reg #(.WIDTH(WIDTH)) u_keep_b (
        .clk(clk), .rst(rst), .load_i(1'b1), .d_i(b_seen), .q_o(keep_b_q)
    );

    assign a_out = a_drive;
    assign b_out = b_drive;
    assign a_oe  = drive_a;
    assign b_oe  = drive_b;

    assert_keep_bus_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(route_a) == ROUTE_KEEP && route_a == ROUTE_KEEP)
            |-> (a_out == $past(a_out) && b_out == $past(b_out)));

    assert_stored_cross_R8: assert property (@(posedge clk) disable iff (rst)
        (a_oe && b_oe && sel_ab && sel_ba && !rise_vec[0] && !rise_vec[1])
            |=> (!(a_oe && b_oe && sel_ab && sel_ba)) || $stable(a_out));

endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic cap_ab = 1'b0, cap_ba = 1'b0;
    logic [7:0] a_in, a_out, b_in, b_out;
    logic a_oe, b_oe;
    logic [7:0] ext_a = 8'h00, ext_b = 8'h00, hold_a = 8'h00, hold_b = 8'h00;
    logic ext_a_en = 1'b0, ext_b_en = 1'b0;
    int errs = 0, checks = 0;

    always #10 clk = ~clk;

    bus_xcvr_reg dut (
        .clk(clk), .rst(rst), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Bus resolvers: external driver or keeper on each bus.
    assign a_in = ext_a_en ? ext_a : hold_a;
    assign b_in = ext_b_en ? ext_b : hold_b;

    always @(negedge clk) begin
        hold_a <= a_oe ? a_out : a_in;
        hold_b <= b_oe ? b_out : b_in;
        if ((a_oe && ext_a_en) || (b_oe && ext_b_en)) begin
            errs++; checks++;
            $display("FAIL R3 bus conflict: a_oe=%0b exta=%0b b_oe=%0b extb=%0b (expected no overlap)",
                     a_oe, ext_a_en, b_oe, ext_b_en);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic isolate();
        en_ab = 1'b0; en_ba_n = 1'b1;
    endtask

    task automatic store_a(input logic [7:0] v);
        isolate(); ext_a_en = 1'b1; ext_a = v; cap_ab = 1'b1;
        cyc(4); cap_ab = 1'b0; cyc(3);
    endtask

    task automatic store_b(input logic [7:0] v);
        isolate(); ext_b_en = 1'b1; ext_b = v; cap_ba = 1'b1;
        cyc(4); cap_ba = 1'b0; cyc(3);
    endtask

    initial begin
        fork
            begin
                #3000000;
                errs++; checks++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        join_none

        cyc(3); rst = 1'b0; cyc(1);

        // R1 reset state seen through stored mode, both sides driving
        en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; #1;
        chk("R1 b_out after reset", b_out, 8'h00);
        chk("R1 a_out after reset", a_out, 8'h00);

        // R2 / R3 enable decode over all four combinations
        for (int e = 0; e < 4; e++) begin
            en_ab = e[0]; en_ba_n = e[1]; #1;
            chk("R2 b_oe", {7'b0, b_oe}, {7'b0, e[0]});
            chk("R2 a_oe", {7'b0, a_oe}, {7'b0, ~e[1]});
            if (!e[0] && e[1]) chk("R3 isolation", {6'b0, a_oe, b_oe}, 8'h00);
        end
        isolate(); sel_ab = 1'b0; sel_ba = 1'b0; cyc(1);

        // Sweep byte patterns
        for (int i = 0; i < 12; i++) begin
            logic [7:0] v;
            v = 8'(i * 8'h2D + 8'h13);
            store_a(v);            // R3: loads while isolated (R4)
            store_b(~v);           // R5
            ext_a_en = 1'b0; ext_b_en = 1'b0;
            en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; #1;
            chk("R8 cross b_out", b_out, v);
            chk("R8 cross a_out", a_out, ~v);
            // R7 single direction stored
            en_ba_n = 1'b1; #1;
            chk("R7 stored A to B", b_out, v);
            en_ab = 1'b0; en_ba_n = 1'b0; #1;
            chk("R7 stored B to A", a_out, ~v);
            // R6 live each direction
            en_ba_n = 1'b1; cyc(1);
            ext_a_en = 1'b1; ext_a = v ^ 8'h5A; en_ab = 1'b1; sel_ab = 1'b0; #1;
            chk("R6 live A to B", b_out, v ^ 8'h5A);
            en_ab = 1'b0; ext_a_en = 1'b0; cyc(1);
            ext_b_en = 1'b1; ext_b = v ^ 8'hA5; en_ba_n = 1'b0; sel_ba = 1'b0; #1;
            chk("R6 live B to A", a_out, v ^ 8'hA5);
            en_ba_n = 1'b1; ext_b_en = 1'b0; cyc(1);
        end

        // R4 capture while B drives stored data (enables/selects do not block)
        store_a(8'h21);
        ext_a_en = 1'b1; ext_a = 8'h9E; en_ab = 1'b1; sel_ab = 1'b1; cap_ab = 1'b1;
        cyc(2); #1;
        chk("R4 not yet loaded", b_out, 8'h21);
        cyc(2); #1;
        chk("R4 loaded while driving", b_out, 8'h9E);
        cap_ab = 1'b0; cyc(3);

        // R12 held strobe captures once
        isolate(); ext_a = 8'h44; cap_ab = 1'b1; cyc(5);
        ext_a = 8'hBB; cyc(6);
        en_ab = 1'b1; sel_ab = 1'b1; ext_a_en = 1'b1; #1;
        chk("R12 held strobe single capture", b_out, 8'h44);
        cap_ab = 1'b0; cyc(3); cap_ab = 1'b1; cyc(4); #1;
        chk("R12 new edge captures", b_out, 8'hBB);
        cap_ab = 1'b0; cyc(3);

        // R10 B driving live A data; cap_ba stores bus A value into B register
        isolate(); ext_b_en = 1'b0; ext_a_en = 1'b1; ext_a = 8'h5A;
        en_ab = 1'b1; sel_ab = 1'b0; cap_ba = 1'b1; cyc(4); cap_ba = 1'b0; cyc(3);
        isolate(); ext_a_en = 1'b0; cyc(1);
        en_ba_n = 1'b0; sel_ba = 1'b1; #1;
        chk("R10 B register took driven value", a_out, 8'h5A);
        isolate(); cyc(1);

        // R9 both live: each bus keeps its last value
        ext_a_en = 1'b1; ext_a = 8'h3C; ext_b_en = 1'b1; ext_b = 8'hC3; cyc(2);
        ext_a_en = 1'b0; ext_b_en = 1'b0; cyc(2);
        sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0; #1;
        chk("R9 bus A kept", a_out, 8'h3C);
        chk("R9 bus B kept", b_out, 8'hC3);
        cyc(6); #1;
        chk("R9 bus A still kept", a_out, 8'h3C);
        chk("R9 bus B still kept", b_out, 8'hC3);
        isolate(); cyc(2);

        // R11 select toggling: equal data unchanged, differing data immediate
        store_a(8'h77);
        ext_a_en = 1'b1; ext_a = 8'h77; en_ab = 1'b1; sel_ab = 1'b0; #1;
        chk("R11 equal live", b_out, 8'h77);
        sel_ab = 1'b1; #1;
        chk("R11 equal stored no change", b_out, 8'h77);
        ext_a = 8'h11; #1;
        chk("R11 stored ignores bus", b_out, 8'h77);
        sel_ab = 1'b0; #1;
        chk("R11 immediate switch to live", b_out, 8'h11);
        isolate(); cyc(2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule